// File: doc/BRIEF.md
# Reset Sequencing Controller with Bidirectional Reset Pin

This block decides when a microcontroller-style core is held in reset, and for how long. Four sources can start a reset: the reset pin, sampled through a synchronizer and a debouncer; a separate asynchronous reset line; a software request; and a watchdog overflow. Each reset runs a fixed internal sequence of `SEQ_CYCLES` clocks, 1024 by default. While the sequence runs, the core reset output is high. The active-low reset output to the board goes low when the sequence starts. It stays low after the sequence ends, until the core signals end of initialization.

The reset pin can also be driven. If the bidirectional enable bit was set when a sequence started, the block turns on an open-drain pull-down on the reset pin for that whole sequence. It releases the pull-down when the sequence ends. A watchdog overflow that arrives during an external bus cycle waits for the programmed wait states to finish. The cycle then either completes or is aborted, depending on the bus ready handshake. Configuration bits are captured from a parallel port, and how many of them are captured depends on the reset type. The block also records a cause code for the most recent reset. It drives the discharge and charge enables for the reset-delay capacitor, and it locks the configuration register once initialization has ended.

Top module: `rst_seq_ctrl`

## Requirements
- R1: A software request that is high at a clock edge starts a sequence at that edge. The cause becomes 3 and the latched port configuration is unchanged.
- R2: The core reset output is high for exactly `SEQ_CYCLES` clock edges after the edge that starts or last restarts a sequence. After that it falls and the block returns to normal run.
- R3: The reset output goes low at every sequence start and at power-on reset. It goes high one edge after an end-of-initialization strobe in run mode. A strobe given while a sequence is running has no effect.
- R4: A reset request during a running sequence restarts the count from zero. No second sequence is queued.
- R5: A reset pin that is low for two consecutive synchronized samples starts a sequence. This is three edges after the pin falls, and the sequence keeps restarting while the pin stays low. A one-cycle low glitch starts nothing. This reset latches all port bits and sets the cause to 1.
- R6: A low level on the asynchronous reset line, after a two-flop synchronizer, starts a sequence. It latches all port bits and sets the cause to 2.
- R7: A watchdog overflow with no bus cycle in progress starts a sequence at once and sets the cause to 4. Port bits 12..6 are latched again, configuration bits 5..2 are cleared, and all other configuration bits keep their value.
- R8: A watchdog overflow during a bus cycle delays the sequence until the wait-done strobe. The cycle is aborted (a one-cycle abort pulse) only if the cycle uses ready and the synchronized ready_n is high. Otherwise it completes.
- R9: Bit 3 of the configuration register is the bidirectional enable and bit 5 is the power-down configuration. Writes take effect only while initialization has not ended. Every sequence start clears bit 3.
- R10: The pin pull-down is on for a whole sequence when bit 3 was set at its start, and off at its end. The block's own pull-down never starts a further reset.
- R11: If the low-voltage input is high while the synchronized pin is low or the pull-down is on, the pull-down turns off and the sequence restarts with cause 2.
- R12: The discharge enable equals the synchronized pin-low level, two edges after the pin. The charge enable is set at sequence end when bit 5 is set, and is cleared at every sequence start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| por_n | input | 1 | Power-on reset of this block, active low |
| rst_pin_n | input | 1 | Reset pin level (includes own pull-down) |
| async_rst_n | input | 1 | Asynchronous reset line, active low |
| sw_rst_req | input | 1 | Software reset request |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| bus_active | input | 1 | External bus cycle in progress |
| bus_uses_ready | input | 1 | Current cycle uses the ready handshake |
| bus_waits_done | input | 1 | Programmed wait states finished |
| ready_n | input | 1 | Bus ready, active low |
| lowv | input | 1 | Low-voltage indication on reset-delay input |
| einit | input | 1 | End-of-initialization strobe |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | CFG_W | Configuration write data |
| port_in | input | PORT_W | Parallel port configuration inputs |
| core_rst | output | 1 | Core held in reset (sequence running) |
| rst_out_n | output | 1 | Reset output, active low |
| pin_pd | output | 1 | Open-drain pull-down enable on reset pin |
| dly_dischg | output | 1 | Reset-delay capacitor discharge enable |
| dly_chg | output | 1 | Reset-delay capacitor charge enable |
| bus_abort | output | 1 | One-cycle abort of the running bus cycle |
| sys_cfg | output | CFG_W | Configuration register |
| cfg_q | output | PORT_W | Latched port configuration |
| cause | output | 3 | Last reset cause: 0 power-on, 1 pin, 2 async, 3 software, 4 watchdog |

## Verification
Software and watchdog requests, end-of-initialization strobes and wait-done strobes act on the first edge that samples them. The asynchronous line acts two edges after it falls, and the pin three edges after it falls. After a pin release, the sequence ends `SEQ_CYCLES`+1 edges after the release edge. The bench drives inputs and samples outputs on falling edges. It counts rising edges from each stimulus and checks the core reset in the last cycle before the computed end and in the first cycle after it. Abort and pull-down changes are checked in the half cycle after the edge that causes them.

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int SEQ_CYCLES = 1024,
  parameter int PORT_W     = 16,
  parameter int CFG_W      = 8,
  parameter int WD_HI      = 12,
  parameter int WD_LO      = 6,
  parameter int CLR_HI     = 5,
  parameter int CLR_LO     = 2,
  parameter int BIDIR_BIT  = 3,
  parameter int PWD_BIT    = 5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin_n,
  input  logic              async_rst_n,
  input  logic              sw_rst_req,
  input  logic              wdt_ovf,
  input  logic              bus_active,
  input  logic              bus_uses_ready,
  input  logic              bus_waits_done,
  input  logic              ready_n,
  input  logic              lowv,
  input  logic              einit,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [PORT_W-1:0] port_in,
  output logic              core_rst,
  output logic              rst_out_n,
  output logic              pin_pd,
  output logic              dly_dischg,
  output logic              dly_chg,
  output logic              bus_abort,
  output logic [CFG_W-1:0]  sys_cfg,
  output logic [PORT_W-1:0] cfg_q,
  output logic [2:0]        cause
);

  localparam int CW = $clog2(SEQ_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(SEQ_CYCLES - 1);

  function automatic logic [PORT_W-1:0] field(input int hi, input int lo);
    logic [PORT_W-1:0] m;
    for (int i = 0; i < PORT_W; i++) m[i] = (i >= lo) && (i <= hi);
    return m;
  endfunction

  localparam logic [PORT_W-1:0] WD_MASK  = field(WD_HI, WD_LO);
  localparam logic [PORT_W-1:0] CLR_MASK = field(CLR_HI, CLR_LO);

  localparam logic [2:0] C_PIN = 3'd1, C_ASY = 3'd2, C_SW = 3'd3, C_WDT = 3'd4;

  typedef enum logic [1:0] {S_RUN, S_DRAIN, S_SEQ} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    pin_sh;
  logic [1:0]    asy_sh, rdy_sh, pd_hist;
  logic          einit_done;

  wire pin_low  = ~pin_sh[1];
  wire pd_mask  = pin_pd | pd_hist[0] | pd_hist[1];
  wire pin_req  = ~pin_sh[1] & ~pin_sh[2] & ~pd_mask;
  wire lv_kill  = lowv & (pin_low | pin_pd);
  wire asy_req  = ~asy_sh[1] | lv_kill;
  wire in_run   = (st == S_RUN);
  wire in_drain = (st == S_DRAIN);
  wire in_seq   = (st == S_SEQ);
  wire wd_req   = (wdt_ovf & ((in_run & ~bus_active) | in_seq)) | (in_drain & bus_waits_done);
  wire drain_go = in_run & wdt_ovf & bus_active;
  wire abort_now = in_drain & bus_waits_done & bus_uses_ready & rdy_sh[1];
  wire start    = asy_req | pin_req | wd_req | sw_rst_req;

  logic [2:0] nxt_cause;
  always_comb begin
    if (asy_req)     nxt_cause = C_ASY;
    else if (pin_req) nxt_cause = C_PIN;
    else if (wd_req)  nxt_cause = C_WDT;
    else              nxt_cause = C_SW;
  end

  assign core_rst   = in_seq;
  assign dly_dischg = pin_low;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pin_sh  <= 3'b111;
      asy_sh  <= 2'b11;
      rdy_sh  <= 2'b11;
      pd_hist <= 2'b00;
    end else begin
      pin_sh  <= {pin_sh[1:0], rst_pin_n};
      asy_sh  <= {asy_sh[0], async_rst_n};
      rdy_sh  <= {rdy_sh[0], ready_n};
      pd_hist <= {pd_hist[0], pin_pd};
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st         <= S_SEQ;
      cnt        <= '0;
      cause      <= 3'd0;
      cfg_q      <= '0;
      rst_out_n  <= 1'b0;
      einit_done <= 1'b0;
      sys_cfg    <= '0;
      pin_pd     <= 1'b0;
      dly_chg    <= 1'b0;
      bus_abort  <= 1'b0;
    end else begin
      bus_abort <= abort_now;
      if (start) begin
        st                 <= S_SEQ;
        cnt                <= '0;
        cause              <= nxt_cause;
        rst_out_n          <= 1'b0;
        einit_done         <= 1'b0;
        sys_cfg[BIDIR_BIT] <= 1'b0;
        pin_pd             <= (pin_pd | sys_cfg[BIDIR_BIT]) & ~lv_kill;
        dly_chg            <= 1'b0;
        if (nxt_cause == C_ASY || nxt_cause == C_PIN)
          cfg_q <= port_in;
        else if (nxt_cause == C_WDT)
          cfg_q <= (cfg_q & ~(WD_MASK | CLR_MASK)) | (port_in & WD_MASK);
      end else begin
        if (cfg_wr && !einit_done) sys_cfg <= cfg_wdata;
        case (st)
          S_RUN: begin
            if (drain_go) st <= S_DRAIN;
            if (einit && !einit_done) begin
              einit_done <= 1'b1;
              rst_out_n  <= 1'b1;
            end
          end
          S_SEQ: begin
            if (cnt == LAST) begin
              st      <= S_RUN;
              pin_pd  <= 1'b0;
              dly_chg <= sys_cfg[PWD_BIT];
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r3_out_low_in_seq: assert property (@(posedge clk) disable iff (!por_n)
    core_rst |-> !rst_out_n);

  a_r3_release_only_in_run: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_out_n) |-> !core_rst);

  a_r10_pd_within_seq: assert property (@(posedge clk) disable iff (!por_n)
    pin_pd |-> core_rst);

  a_r8_abort_is_wdt: assert property (@(posedge clk) disable iff (!por_n)
    bus_abort |-> (core_rst && cause == C_WDT));

  a_r1_sw_starts: assert property (@(posedge clk) disable iff (!por_n)
    sw_rst_req |=> core_rst);

  a_r2_full_length: assert property (@(posedge clk) disable iff (!por_n)
    $fell(core_rst) |-> $past(cnt) == LAST);

  a_r9_locked: assert property (@(posedge clk) disable iff (!por_n)
    (einit_done && !start) |=> $stable(sys_cfg));

endmodule

// File: tb/sim_rst_seq_ctrl.sv
`timescale 1ns/1ps
module sim_rst_seq_ctrl;
  localparam int N = 1024;

  logic clk = 0;
  always #4 clk = ~clk;

  logic por_n, ext_pin_n, async_rst_n, sw_rst_req, wdt_ovf;
  logic bus_active, bus_uses_ready, bus_waits_done, ready_n, lowv, einit, cfg_wr;
  logic [7:0]  cfg_wdata;
  logic [15:0] port_in;
  logic core_rst, rst_out_n, pin_pd, dly_dischg, dly_chg, bus_abort;
  logic [7:0]  sys_cfg;
  logic [15:0] cfg_q;
  logic [2:0]  cause;
  wire rst_pin_n = ext_pin_n & ~pin_pd;

  rst_seq_ctrl #(.SEQ_CYCLES(N)) u0 (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .async_rst_n(async_rst_n),
    .sw_rst_req(sw_rst_req), .wdt_ovf(wdt_ovf), .bus_active(bus_active),
    .bus_uses_ready(bus_uses_ready), .bus_waits_done(bus_waits_done), .ready_n(ready_n),
    .lowv(lowv), .einit(einit), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .port_in(port_in),
    .core_rst(core_rst), .rst_out_n(rst_out_n), .pin_pd(pin_pd), .dly_dischg(dly_dischg),
    .dly_chg(dly_chg), .bus_abort(bus_abort), .sys_cfg(sys_cfg), .cfg_q(cfg_q), .cause(cause));

  int checks = 0, fails = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_end();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!core_rst) break;
    end
  endtask

  task automatic do_einit();
    einit = 1; @(negedge clk); einit = 0;
  endtask

  task automatic cfg_write(input logic [7:0] d);
    cfg_wr = 1; cfg_wdata = d; @(negedge clk); cfg_wr = 0;
  endtask

  task automatic sw_pulse();
    sw_rst_req = 1; @(negedge clk); sw_rst_req = 0;
  endtask

  task automatic wdt_pulse();
    wdt_ovf = 1; @(negedge clk); wdt_ovf = 0;
  endtask

  // {kind, port, expected cfg, expected cause}; kind 1 pin, 2 async, 3 sw, 4 wdt
  localparam logic [37:0] VEC [6] = '{
    {3'd2, 16'hFFFF, 16'hFFFF, 3'd2},
    {3'd4, 16'h0000, 16'hE003, 3'd4},
    {3'd3, 16'h1234, 16'hE003, 3'd3},
    {3'd2, 16'h1234, 16'h1234, 3'd2},
    {3'd4, 16'hFFFF, 16'h1FC0, 3'd4},
    {3'd1, 16'hA5A5, 16'hA5A5, 3'd1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    por_n = 0; ext_pin_n = 1; async_rst_n = 1; sw_rst_req = 0; wdt_ovf = 0;
    bus_active = 0; bus_uses_ready = 0; bus_waits_done = 0; ready_n = 0;
    lowv = 0; einit = 0; cfg_wr = 0; cfg_wdata = 0; port_in = 0;
    repeat (3) @(negedge clk);
    chk("R3 reset rst_out_n", rst_out_n, 0);
    chk("R2 reset core_rst", core_rst, 1);
    chk("R9 reset sys_cfg", sys_cfg, 0);
    chk("R10 reset pin_pd", pin_pd, 0);
    chk("R3 reset cause", cause, 0);
    por_n = 1;
    wait_end();
    do_einit();
    chk("R3 release after einit", rst_out_n, 1);

    for (int v = 0; v < 6; v++) begin
      logic [2:0] k;
      string tg;
      k = VEC[v][37:35];
      port_in = VEC[v][34:19];
      case (k)
        3'd1: begin tg = "R5"; ext_pin_n = 0; repeat (4) @(negedge clk); ext_pin_n = 1; end
        3'd2: begin tg = "R6"; async_rst_n = 0; repeat (3) @(negedge clk); async_rst_n = 1; end
        3'd3: begin tg = "R1"; sw_pulse(); end
        default: begin tg = "R7"; wdt_pulse(); end
      endcase
      chk({tg, " seq started"}, core_rst, 1);
      wait_end();
      do_einit();
      chk({tg, " cfg_q"}, cfg_q, VEC[v][18:3]);
      chk({tg, " cause"}, cause, VEC[v][2:0]);
      chk("R3 rst_out_n after einit", rst_out_n, 1);
    end

    // R1, R2, R3: exact length, einit inside sequence ignored
    sw_pulse();
    chk("R1 core_rst after request edge", core_rst, 1);
    chk("R3 rst_out_n low at start", rst_out_n, 0);
    do_einit();
    repeat (N - 2) @(negedge clk);
    chk("R2 still in reset at last cycle", core_rst, 1);
    @(negedge clk);
    chk("R2 reset ended", core_rst, 0);
    chk("R3 einit during seq ignored", rst_out_n, 0);
    do_einit();
    chk("R3 release one edge after einit", rst_out_n, 1);

    // R4: restart mid sequence
    sw_pulse();
    repeat (99) @(negedge clk);
    sw_pulse();
    repeat (N - 1) @(negedge clk);
    chk("R4 restarted sequence still running", core_rst, 1);
    @(negedge clk);
    chk("R4 restarted sequence ends", core_rst, 0);
    do_einit();

    // R9, R10: bidirectional pull-down
    sw_pulse();
    wait_end();
    cfg_write(8'h08);
    chk("R9 write before einit", sys_cfg, 8'h08);
    do_einit();
    cfg_write(8'h00);
    chk("R9 write after einit ignored", sys_cfg, 8'h08);
    sw_pulse();
    chk("R10 pull-down on at start", pin_pd, 1);
    chk("R9 enable cleared by reset", sys_cfg[3], 0);
    repeat (5) @(negedge clk);
    chk("R12 discharge while pin pulled", dly_dischg, 1);
    wait_end();
    chk("R10 pull-down released at end", pin_pd, 0);
    repeat (10) @(negedge clk);
    chk("R10 own pull-down no retrigger", core_rst, 0);

    // R11 and R12 charge enable
    cfg_write(8'h28);
    do_einit();
    sw_pulse();
    chk("R10 pull-down on again", pin_pd, 1);
    repeat (50) @(negedge clk);
    lowv = 1; @(negedge clk); lowv = 0;
    chk("R11 pull-down disabled", pin_pd, 0);
    chk("R11 cause async", cause, 2);
    chk("R11 still in reset", core_rst, 1);
    wait_end();
    chk("R12 charge enable at end", dly_chg, 1);
    do_einit();

    // R8: watchdog during bus cycle
    for (int t = 0; t < 3; t++) begin
      bus_active = 1;
      bus_uses_ready = (t != 2);
      ready_n = (t != 1);
      repeat (3) @(negedge clk);
      wdt_pulse();
      repeat (5) @(negedge clk);
      chk("R8 waits for wait states", core_rst, 0);
      bus_waits_done = 1; @(negedge clk); bus_waits_done = 0;
      chk("R8 seq after wait states", core_rst, 1);
      chk("R8 abort decision", bus_abort, (t == 0));
      if (t == 0) chk("R12 charge cleared at start", dly_chg, 0);
      @(negedge clk);
      chk("R8 abort is one cycle", bus_abort, 0);
      bus_active = 0;
      wait_end();
      do_einit();
    end

    // R5: glitch ignored, discharge follows pin
    ext_pin_n = 0; @(negedge clk); ext_pin_n = 1;
    @(negedge clk);
    chk("R12 discharge follows pin", dly_dischg, 1);
    repeat (6) @(negedge clk);
    chk("R5 glitch ignored", core_rst, 0);

    // R5: sequence timing after pin release
    ext_pin_n = 0;
    repeat (6) @(negedge clk);
    ext_pin_n = 1;
    @(negedge clk);
    repeat (N) @(negedge clk);
    chk("R5 held until release plus length", core_rst, 1);
    @(negedge clk);
    chk("R5 ends after release", core_rst, 0);
    chk("R5 cause pin", cause, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule